// File: doc/BRIEF.md
# Phase-Continuous Two-Tone Square-Wave Modulator

This block turns a serial bit stream into a square-wave binary frequency-shift-keyed carrier. A producer offers one bit at a time on a valid/ready handshake. For every accepted bit the block emits a whole number of carrier cycles, so both symbols occupy exactly the same bit time. A one is sent as eight cycles of a fast tone, each seven master ticks long. A zero is sent as seven cycles of a slow tone, each eight master ticks long. Either way a bit lasts 56 ticks. With a master clock of 56 times the bit rate (about 31.61 MHz for a 564.48 kbit/s stream), the tones come out near 4.516 MHz and 3.951 MHz.

The tone changes only at a bit boundary. Every bit starts with a low-to-high transition and never with a partial cycle. The next bit is taken on the final tick of the current one. If the producer has nothing ready at that moment, the line is parked low and the block reports idle until data arrives.

The controller has two states. In `ST_IDLE` the line is low and `bit_ready` is high. It leaves through LOAD (`bit_valid` seen) to `ST_SEND`. `ST_SEND` takes one of two paths on the final tick of a bit. CHAIN (`bit_valid` high) stays in `ST_SEND` with the new bit. DRAIN (`bit_valid` low) returns to `ST_IDLE`.

Top module: `fsk_mod`

## Requirements
- R1: While the synchronous active-high `rst` is held, and in the first cycle after its release, `fsk_out` is 0, `idle` is 1 and `bit_ready` is 1.
- R2: When `bit_valid` is 1 in a cycle where the block is idle, the bit is accepted in that cycle. In the following cycle `fsk_out` is 1 and `idle` is 0.
- R3: A bit accepted with `bit_data` = 1 produces 8 carrier cycles of 7 ticks each. Each cycle is 4 ticks high followed by 3 ticks low, for 56 ticks in total.
- R4: A bit accepted with `bit_data` = 0 produces 7 carrier cycles of 8 ticks each. Each cycle is 4 ticks high followed by 4 ticks low, for 56 ticks in total.
- R5: When a bit is waiting on the 56th tick of the current bit, it is accepted on that tick. The next tick is the first high tick of the new bit, with no gap and no partial cycle.
- R6: During a bit, `bit_ready` is 0 on every tick except the 56th. `bit_valid` and `bit_data` have no effect on the waveform while `bit_ready` is 0.
- R7: When no bit is offered on the 56th tick, the block is idle from the next cycle on: `fsk_out` stays 0 and `idle` stays 1 until a bit is accepted.
- R8: `bit_taken` is 1 in exactly the cycles where a bit is consumed, that is, where both `bit_ready` and `bit_valid` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 56 ticks per bit |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | A bit is offered |
| bit_data | input | 1 | Value of the offered bit |
| bit_ready | output | 1 | The block will take a bit this cycle |
| bit_taken | output | 1 | Strobe: a bit is consumed this cycle |
| fsk_out | output | 1 | Modulated square wave |
| idle | output | 1 | No bit in flight; line parked low |

## Verification
A handshake in cycle t makes the waveform due from cycle t+1 through t+56. `bit_ready` and `bit_taken` respond within the same cycle as the offer, and `idle` falls at t+1. The driver watches for the handshake just before the accepting edge and queues the 56 expected line samples. The monitor pops one sample per cycle in the middle of the cycle. Its queue depth also tells it when `bit_ready` is due (depth one or zero) and when `idle` is due (depth zero). No check depends on guessing a delay.

// File: rtl/fsk_mod_pkg.sv
package fsk_mod_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } fsk_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fsk_tone_gen.sv
// Tick counter inside one carrier cycle; shapes the square wave.
module fsk_tone_gen #(
    parameter int ONE_PERIOD  = 7,
    parameter int ZERO_PERIOD = 8,
    parameter int HIGH_TICKS  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    input  logic sel_one,
    output logic wave,
    output logic cyc_end
);
    import fsk_mod_pkg::*;

    localparam int MAXP = max2(ONE_PERIOD, ZERO_PERIOD);
    localparam int TW   = $clog2(MAXP + 1);

    logic [TW-1:0] tick_q;
    logic [TW-1:0] period_last;

    always_comb begin
        period_last = sel_one ? TW'(ONE_PERIOD - 1) : TW'(ZERO_PERIOD - 1);
        cyc_end     = run && (tick_q == period_last);
        wave        = run && (tick_q < TW'(HIGH_TICKS));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
        end else if (restart) begin
            tick_q <= '0;
        end else if (run) begin
            tick_q <= cyc_end ? '0 : tick_q + 1'b1;
        end else begin
            tick_q <= '0;
        end
    end

endmodule

// File: rtl/fsk_cycle_count.sv
// Counts carrier cycles within one bit; flags the final tick of the bit.
module fsk_cycle_count #(
    parameter int ONE_CYCLES  = 8,
    parameter int ZERO_CYCLES = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic cyc_end,
    input  logic sel_one,
    output logic bit_end
);
    import fsk_mod_pkg::*;

    localparam int MAXC = max2(ONE_CYCLES, ZERO_CYCLES);
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cyc_q;
    logic [CW-1:0] cyc_last;

    always_comb begin
        cyc_last = sel_one ? CW'(ONE_CYCLES - 1) : CW'(ZERO_CYCLES - 1);
        bit_end  = cyc_end && (cyc_q == cyc_last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= '0;
        end else if (restart) begin
            cyc_q <= '0;
        end else if (cyc_end) begin
            cyc_q <= bit_end ? '0 : cyc_q + 1'b1;
        end
    end

endmodule

// File: rtl/fsk_mod_fsm.sv
// Bit-level controller: IDLE/SEND with LOAD, CHAIN and DRAIN transitions.
module fsk_mod_fsm (
    input  logic clk,
    input  logic rst,
    input  logic bit_valid,
    input  logic bit_data,
    input  logic bit_end,
    output logic bit_ready,
    output logic bit_taken,
    output logic run,
    output logic cur_bit,
    output logic idle
);
    import fsk_mod_pkg::*;

    fsk_state_e state_q, state_d;
    logic       cur_bit_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (bit_valid)             state_d = ST_SEND; // LOAD
            ST_SEND: if (bit_end && !bit_valid) state_d = ST_IDLE; // DRAIN
            default:                            state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cur_bit_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (bit_taken) cur_bit_q <= bit_data; // LOAD or CHAIN
        end
    end

    always_comb begin
        bit_ready = 1'b0;
        run       = 1'b0;
        idle      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                bit_ready = 1'b1;
                idle      = 1'b1;
            end
            ST_SEND: begin
                bit_ready = bit_end;
                run       = 1'b1;
            end
            default: idle = 1'b1;
        endcase
        bit_taken = bit_ready && bit_valid;
        cur_bit   = cur_bit_q;
    end

endmodule

// File: rtl/fsk_mod.sv
// Phase-continuous two-tone square-wave modulator, top level.
module fsk_mod #(
    parameter int ONE_CYCLES  = 8,
    parameter int ONE_PERIOD  = 7,
    parameter int ZERO_CYCLES = 7,
    parameter int ZERO_PERIOD = 8,
    parameter int HIGH_TICKS  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_valid,
    input  logic bit_data,
    output logic bit_ready,
    output logic bit_taken,
    output logic fsk_out,
    output logic idle
);
    localparam int BIT_TICKS = ONE_CYCLES * ONE_PERIOD;

    logic run, cur_bit, cyc_end, bit_end;

    fsk_mod_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .bit_data  (bit_data),
        .bit_end   (bit_end),
        .bit_ready (bit_ready),
        .bit_taken (bit_taken),
        .run       (run),
        .cur_bit   (cur_bit),
        .idle      (idle)
    );

    fsk_tone_gen #(
        .ONE_PERIOD  (ONE_PERIOD),
        .ZERO_PERIOD (ZERO_PERIOD),
        .HIGH_TICKS  (HIGH_TICKS)
    ) u_tone (
        .clk     (clk),
        .rst     (rst),
        .restart (bit_taken),
        .run     (run),
        .sel_one (cur_bit),
        .wave    (fsk_out),
        .cyc_end (cyc_end)
    );

    fsk_cycle_count #(
        .ONE_CYCLES  (ONE_CYCLES),
        .ZERO_CYCLES (ZERO_CYCLES)
    ) u_cycles (
        .clk     (clk),
        .rst     (rst),
        .restart (bit_taken),
        .cyc_end (cyc_end),
        .sel_one (cur_bit),
        .bit_end (bit_end)
    );

    initial begin
        assert (BIT_TICKS == ZERO_CYCLES * ZERO_PERIOD)
            else $error("both symbols must fill the same bit time");
    end

endmodule

// File: rtl/fsk_mod_checker.sv
module fsk_mod_checker #(
    parameter int HIGH_TICKS = 4,
    parameter int BIT_TICKS  = 56
) (
    input logic clk,
    input logic rst,
    input logic bit_valid,
    input logic bit_ready,
    input logic bit_taken,
    input logic fsk_out,
    input logic idle
);
    logic [7:0]  hi_len;
    logic [15:0] bit_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_len  <= '0;
            bit_len <= '0;
        end else begin
            hi_len  <= fsk_out ? ((hi_len == 8'hFF) ? hi_len : hi_len + 1'b1) : '0;
            bit_len <= bit_taken ? 16'd1 : ((bit_len == 16'hFFFF) ? bit_len : bit_len + 1'b1);
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!fsk_out && idle && bit_ready));

    assert_start_high_R2: assert property (@(posedge clk) disable iff (rst)
        bit_taken |=> (fsk_out && !idle));

    assert_high_phase_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(fsk_out) |-> (hi_len == 8'(HIGH_TICKS)));

    assert_bit_length_R5: assert property (@(posedge clk) disable iff (rst)
        (bit_taken && !idle) |-> (bit_len == 16'(BIT_TICKS)));

    assert_no_midbit_exit_R6: assert property (@(posedge clk) disable iff (rst)
        (!idle && !bit_ready) |=> !idle);

    assert_idle_low_R7: assert property (@(posedge clk) disable iff (rst)
        idle |-> !fsk_out);

    assert_taken_needs_valid_R8: assert property (@(posedge clk) disable iff (rst)
        bit_taken |-> bit_valid);

endmodule

bind fsk_mod fsk_mod_checker #(
    .HIGH_TICKS (HIGH_TICKS),
    .BIT_TICKS  (ONE_CYCLES * ONE_PERIOD)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_valid (bit_valid),
    .bit_ready (bit_ready),
    .bit_taken (bit_taken),
    .fsk_out   (fsk_out),
    .idle      (idle)
);

// File: tb/fsk_mod_tb.sv
`timescale 1ns/1ps
module fsk_mod_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_valid = 1'b0;
    logic bit_data = 1'b0;
    logic bit_ready, bit_taken, fsk_out, idle;

    int ncmp = 0;
    int nbad = 0;
    logic  mon_en = 1'b0;
    logic  exp_w[$];
    string exp_t[$];

    always #2 clk = ~clk;

    fsk_mod u_dut (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_data(bit_data),
        .bit_ready(bit_ready), .bit_taken(bit_taken), .fsk_out(fsk_out), .idle(idle)
    );

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        ncmp++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // expected 56-sample waveform for one bit (R3 / R4), first sample tagged R2 or R5
    task automatic push_bit(input logic b, input string first_tag);
        int per = b ? 7 : 8;
        int ncy = b ? 8 : 7;
        for (int c = 0; c < ncy; c++)
            for (int t = 0; t < per; t++) begin
                exp_w.push_back(t < 4);
                if (c == 0 && t == 0) exp_t.push_back(first_tag);
                else                  exp_t.push_back(b ? "R3" : "R4");
            end
    endtask

    // driver: offer a bit, wait for the handshake, queue the expected samples
    task automatic send_bit(input logic b);
        @(posedge clk); #1;
        bit_valid = 1'b1;
        bit_data  = b;
        forever begin
            @(negedge clk); #1;
            if (bit_ready) begin
                push_bit(b, idle ? "R2" : "R5");
                break;
            end
        end
    endtask

    task automatic release_valid();
        @(posedge clk); #1;
        bit_valid = 1'b0;
    endtask

    // mid-bit noise on the inputs while ready is low (R6)
    task automatic noise(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            bit_valid = 1'b1;
            bit_data  = ~bit_data;
        end
        @(posedge clk); #1;
        bit_valid = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (mon_en) begin
            int n;
            n = exp_w.size();
            chk(bit_ready, (n <= 1), "R6", "bit_ready");
            chk(bit_taken, (n <= 1) && bit_valid, "R8", "bit_taken");
            chk(idle, (n == 0), "R7", "idle");
            if (n > 0) begin
                logic  w;
                string tg;
                w  = exp_w.pop_front();
                tg = exp_t.pop_front();
                chk(fsk_out, w, tg, "fsk_out");
            end else begin
                chk(fsk_out, 1'b0, "R7", "fsk_out parked");
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(fsk_out, 1'b0, "R1", "fsk_out in reset");
        chk(idle, 1'b1, "R1", "idle in reset");
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        chk(fsk_out, 1'b0, "R1", "fsk_out after reset");
        chk(idle, 1'b1, "R1", "idle after reset");
        chk(bit_ready, 1'b1, "R1", "bit_ready after reset");
        @(posedge clk); #1;
        mon_en = 1'b1;
        repeat (4) @(posedge clk);

        // back-to-back stream mixing both tones (R3, R4, R5)
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b0);
        release_valid();
        // underrun then resume (R7, R2)
        repeat (70) @(posedge clk);
        send_bit(1'b0);
        // inputs toggled mid-bit must be ignored (R6)
        noise(25);
        repeat (60) @(posedge clk);
        send_bit(1'b1);
        noise(30);
        repeat (40) @(posedge clk);
        send_bit(1'b0);
        send_bit(1'b1);
        release_valid();

        while (exp_w.size() != 0) @(posedge clk);
        repeat (5) @(posedge clk);
        @(negedge clk); #1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
    end

endmodule